// File: doc/BRIEF.md
# Masked Vectored Interrupt Controller

This block gathers sixteen level-sensitive interrupt request lines into a pending register and qualifies them with a programmable enable mask. A single combined interrupt output is high whenever any pending line is also enabled. The block also presents a source register that encodes the lowest-numbered qualifying line as a small vector code, so a handler can branch on it without scanning bits.

Software reaches the block through a 16-bit register port: the source register sits at byte offset 0x000 and the read/write enable mask at byte offset 0x002. Reads are combinational from registered state and have no side effects. The combined output comes from a two-state machine (`ST_QUIET`, `ST_RAISED`). It moves `ST_QUIET` to `ST_RAISED` when the next pending and mask values share a set bit, `ST_RAISED` to `ST_QUIET` when they share none, and otherwise holds its state. The output therefore follows the registered pending and mask values on the same edge.

Top module: `irq_vector_ctrl`

## Requirements
- R1: Pending bit i equals request input i as sampled on the previous rising clock edge; it stays set while the input stays high and clears only once the input is low.
- R2: `irq_o` is high exactly when (pending AND mask) is nonzero. It is registered: a change on the request inputs or a mask write shows at `irq_o` one clock edge later and not earlier.
- R3: A read of offset 0x000 returns (k+1)*4 in bits [15:0], where k is the lowest-numbered line that is both pending and enabled. Higher qualifying lines do not affect the code.
- R4: A read of offset 0x000 returns 0 when no line is both pending and enabled, including when lines are pending but masked.
- R5: Offset 0x002 reads back the enable mask in bits [15:0], where bit i enables line i. A write there replaces all 16 bits on the next rising edge.
- R6: After reset the mask is 0x0010, pending is 0, `irq_o` is low and the source register reads 0.
- R7: Reads from any offset other than 0x000 and 0x002 return 0. Writes to any offset other than 0x002, including 0x000, change neither the mask nor `irq_o`.
- R8: Reading the source register changes nothing: repeated reads return the same code and `irq_o` keeps its level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | 16 | Level-sensitive request lines, bit i is line i |
| reg_addr_i | input | 12 | Byte offset of the register access |
| reg_we_i | input | 1 | Write strobe, sampled on the rising edge |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data for `reg_addr_i`, combinational |
| irq_o | output | 1 | Combined interrupt output |

## Verification
A wrong pending or mask bit shows within one clock at `irq_o` and in the source code of any read at 0x000. A corrupted mask also appears directly on a read of 0x002. A state machine stuck in `ST_RAISED` or `ST_QUIET` disagrees with the source register on the edge after the qualifying set changes. A priority encoder that favours the wrong line returns a code for a higher line whenever two lines qualify at once, so the sweeps over every pair of lines expose it.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;

    typedef enum logic [0:0] {
        ST_QUIET  = 1'b0,
        ST_RAISED = 1'b1
    } irq_state_e;

endpackage

// File: rtl/irq_pend_reg.sv
module irq_pend_reg #(
    parameter int N_LINES = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] req_i,
    output logic [N_LINES-1:0] pend_o
);

    // Level-following capture: each bit mirrors its line one edge later.
    for (genvar g = 0; g < N_LINES; g++) begin : g_line
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pend_o[g] <= 1'b0;
            else        pend_o[g] <= req_i[g];
        end
    end

endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
    parameter int               N_LINES  = 16,
    parameter logic [N_LINES-1:0] MASK_RST = 16'h0010
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en_i,
    input  logic [N_LINES-1:0] wdata_i,
    output logic [N_LINES-1:0] mask_o,
    output logic [N_LINES-1:0] mask_next_o
);

    always_comb begin
        mask_next_o = wr_en_i ? wdata_i : mask_o;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mask_o <= MASK_RST;
        else        mask_o <= mask_next_o;
    end

endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
    parameter int N_LINES = 16,
    parameter int CODE_W  = 7
) (
    input  logic [N_LINES-1:0] qual_i,
    output logic [CODE_W-1:0]  code_o
);

    // Scan from the top down so the lowest qualifying line wins last.
    always_comb begin
        code_o = '0;
        for (int i = N_LINES - 1; i >= 0; i--) begin
            if (qual_i[i]) code_o = CODE_W'((i + 1) * 4);
        end
    end

endmodule

// File: rtl/irq_out_fsm.sv
module irq_out_fsm
    import irq_vec_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic any_next_i,
    output logic irq_o
);

    irq_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_QUIET:  if (any_next_i)  state_d = ST_RAISED;
            ST_RAISED: if (!any_next_i) state_d = ST_QUIET;
            default:   state_d = ST_QUIET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_QUIET;
        else        state_q <= state_d;
    end

    always_comb begin
        irq_o = (state_q == ST_RAISED);
    end

endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl #(
    parameter int                 N_LINES  = 16,
    parameter int                 DATA_W   = 16,
    parameter int                 ADDR_W   = 12,
    parameter logic [N_LINES-1:0] MASK_RST = 16'h0010,
    parameter logic [ADDR_W-1:0]  OFF_SRC  = 12'h000,
    parameter logic [ADDR_W-1:0]  OFF_MASK = 12'h002
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [15:0]       req_i,
    input  logic [11:0]       reg_addr_i,
    input  logic              reg_we_i,
    input  logic [15:0]       reg_wdata_i,
    output logic [15:0]       reg_rdata_o,
    output logic              irq_o
);

    localparam int CODE_W = $clog2(N_LINES + 1) + 2;

    logic [N_LINES-1:0] pend_q;
    logic [N_LINES-1:0] mask_q;
    logic [N_LINES-1:0] mask_d;
    logic [N_LINES-1:0] qual;
    logic [CODE_W-1:0]  code;
    logic               mask_wr;
    logic               any_next;
    logic [DATA_W-1:0]  mask_ext;
    logic [DATA_W-1:0]  code_ext;

    assign mask_wr = reg_we_i && (reg_addr_i == OFF_MASK);

    irq_pend_reg #(.N_LINES(N_LINES)) u_pend (
        .clk    (clk),
        .rst_n  (rst_n),
        .req_i  (req_i),
        .pend_o (pend_q)
    );

    irq_mask_reg #(.N_LINES(N_LINES), .MASK_RST(MASK_RST)) u_mask (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en_i     (mask_wr),
        .wdata_i     (reg_wdata_i[N_LINES-1:0]),
        .mask_o      (mask_q),
        .mask_next_o (mask_d)
    );

    assign qual     = pend_q & mask_q;
    assign any_next = |(req_i & mask_d);

    irq_prio_enc #(.N_LINES(N_LINES), .CODE_W(CODE_W)) u_enc (
        .qual_i (qual),
        .code_o (code)
    );

    irq_out_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .any_next_i (any_next),
        .irq_o      (irq_o)
    );

    always_comb begin
        mask_ext = '0;
        mask_ext[N_LINES-1:0] = mask_q;
        code_ext = '0;
        code_ext[CODE_W-1:0] = code;
    end

    always_comb begin
        if (reg_addr_i == OFF_SRC)       reg_rdata_o = code_ext;
        else if (reg_addr_i == OFF_MASK) reg_rdata_o = mask_ext;
        else                             reg_rdata_o = '0;
    end

endmodule

// File: rtl/irq_vector_chk.sv
module irq_vector_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] req_i,
    input logic [11:0] reg_addr_i,
    input logic        reg_we_i,
    input logic [15:0] reg_wdata_i,
    input logic [15:0] reg_rdata_o,
    input logic        irq_o,
    input logic [15:0] pend,
    input logic [15:0] mask
);

    logic [15:0] qual;
    logic [15:0] line_idx;
    logic [15:0] qual_sh;
    logic        mask_hit;

    assign qual     = pend & mask;
    assign line_idx = (reg_rdata_o >> 2) - 16'd1;
    assign qual_sh  = qual >> line_idx;
    assign mask_hit = reg_we_i && (reg_addr_i == 12'h002);

    assert_pend_follow_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> pend == $past(req_i));

    assert_irq_level_R2: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == (qual != 16'd0));

    assert_vec_line_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr_i == 12'h000 && reg_rdata_o != 16'd0)
            |-> (reg_rdata_o[1:0] == 2'b00) && qual_sh[0]);

    assert_vec_none_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr_i == 12'h000 && qual == 16'd0) |-> reg_rdata_o == 16'd0);

    assert_mask_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mask_hit |=> mask == $past(reg_wdata_i));

    assert_mask_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_hit |=> $stable(mask));

    assert_unmapped_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr_i != 12'h000 && reg_addr_i != 12'h002) |-> reg_rdata_o == 16'd0);

endmodule

bind irq_vector_ctrl irq_vector_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_i       (req_i),
    .reg_addr_i  (reg_addr_i),
    .reg_we_i    (reg_we_i),
    .reg_wdata_i (reg_wdata_i),
    .reg_rdata_o (reg_rdata_o),
    .irq_o       (irq_o),
    .pend        (pend_q),
    .mask        (mask_q)
);

// File: tb/sim_irq_vector_ctrl.sv
`timescale 1ns/1ps
module sim_irq_vector_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] req = '0;
    logic [11:0] addr = '0;
    logic        we = 1'b0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    irq_vector_ctrl u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_i       (req),
        .reg_addr_i  (addr),
        .reg_we_i    (we),
        .reg_wdata_i (wdata),
        .reg_rdata_o (rdata),
        .irq_o       (irq)
    );

    function automatic logic [15:0] exp_vec(input logic [15:0] p, input logic [15:0] m);
        logic [15:0] v = '0;
        for (int i = 15; i >= 0; i--) if (p[i] & m[i]) v = 16'((i + 1) * 4);
        return v;
    endfunction

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [11:0] a, output logic [15:0] d);
        addr = a;
        #1 d = rdata;
    endtask

    // Drive at a falling edge, let one rising edge pass, return at the next falling edge.
    task automatic cyc;
        @(negedge clk);
    endtask

    task automatic wr(input logic [11:0] a, input logic [15:0] d);
        addr = a; wdata = d; we = 1'b1;
        cyc();
        we = 1'b0;
    endtask

    task automatic check_state(input string tag, input logic [15:0] p, input logic [15:0] m);
        logic [15:0] d;
        rd(12'h000, d);
        chk({tag, " R3/R4 vector"}, d, exp_vec(p, m));
        chk({tag, " R2 irq"}, {15'd0, irq}, {15'd0, |(p & m)});
    endtask

    initial begin
        logic [15:0] d;
        logic [15:0] m;
        @(negedge clk);
        // R6 reset values while reset is held
        rd(12'h002, d); chk("R6 mask reset", d, 16'h0010);
        rd(12'h000, d); chk("R6 source reset", d, 16'h0000);
        chk("R6 irq reset", {15'd0, irq}, 16'd0);
        rst_n = 1'b1;
        cyc();

        // R2 R1: enabled line 4 raises irq only after the edge
        req = 16'h0010;
        #1 chk("R2 irq not before edge", {15'd0, irq}, 16'd0);
        cyc();
        check_state("R1 line4", 16'h0010, 16'h0010);

        // R5 full-width mask write and readback
        wr(12'h002, 16'hFFFF);
        rd(12'h002, d); chk("R5 mask readback", d, 16'hFFFF);
        m = 16'hFFFF;

        // R3: single line sweep
        for (int k = 0; k < 16; k++) begin
            req = 16'(1) << k;
            cyc();
            check_state("R3 single", req, m);
        end

        // R3: every pair, lowest wins
        for (int k = 0; k < 16; k++) begin
            for (int j = k + 1; j < 16; j++) begin
                req = (16'(1) << k) | (16'(1) << j);
                cyc();
                rd(12'h000, d);
                chk("R3 pair lowest", d, 16'((k + 1) * 4));
            end
        end

        // R1: pending clears when input drops
        req = 16'h0000;
        cyc();
        check_state("R1 drop", 16'h0000, m);

        // R5/R4: mask sweep, all pending
        req = 16'hFFFF;
        for (int k = 0; k < 16; k++) begin
            wr(12'h002, 16'(1) << k);
            check_state("R5 one-hot mask", 16'hFFFF, 16'(1) << k);
            req = ~(16'(1) << k);
            cyc();
            check_state("R4 masked only", ~(16'(1) << k), 16'(1) << k);
            req = 16'hFFFF;
            cyc();
        end

        // R2: mask write drops irq one edge later
        wr(12'h002, 16'h0101);
        req = 16'h0100;
        cyc();
        check_state("R2 mask on", 16'h0100, 16'h0101);
        addr = 12'h002; wdata = 16'h0000; we = 1'b1;
        #1 chk("R2 irq held before edge", {15'd0, irq}, 16'd1);
        cyc();
        we = 1'b0;
        check_state("R2 mask off", 16'h0100, 16'h0000);
        wr(12'h002, 16'h0101);

        // R7: writes elsewhere ignored, reads elsewhere zero
        wr(12'h000, 16'hFFFF);
        wr(12'h004, 16'h0000);
        wr(12'h003, 16'h0000);
        wr(12'h800, 16'h0000);
        rd(12'h002, d); chk("R7 mask untouched", d, 16'h0101);
        check_state("R7 irq untouched", 16'h0100, 16'h0101);
        for (int a = 1; a < 64; a++) begin
            if (a != 2) begin
                rd(12'(a), d); chk("R7 unmapped read", d, 16'h0000);
            end
        end

        // R8: repeated source reads change nothing
        addr = 12'h000;
        for (int n = 0; n < 4; n++) begin
            cyc();
            check_state("R8 repeat read", 16'h0100, 16'h0101);
        end

        // R6: reset again mid-run
        rst_n = 1'b0;
        #1;
        rd(12'h002, d); chk("R6 mask after reset", d, 16'h0010);
        chk("R6 irq after reset", {15'd0, irq}, 16'd0);
        cyc();
        rst_n = 1'b1;
        req = 16'h0000;
        cyc();

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule